// File: doc/BRIEF.md
# Self-Correcting Decade Counter

This block counts a single decimal digit. On every rising clock edge with the count enable high it steps through the codes 0000 to 1001 and then returns to 0000. Each of the four state bits sits in its own JK flip-flop. A small piece of combinational excitation logic computes the J and K inputs of every bit. These equations were minimised by treating the six unused codes as don't-cares wherever their required successor allowed it.

The six codes above nine cannot occur in normal counting, but a glitch or an upset could still produce one. If the counter ever holds such a code, it returns to 0000 on the next rising edge. A terminal-count flag marks the cycle in which the counter sits on nine with the enable high, so the flag can feed the enable of a further digit. A test load port writes any 4-bit code into the flip-flops through their J and K inputs. This lets a bench place the counter in an unused code and watch it recover.

Top module: `decade_jk_counter`

## Requirements
- R1: While rst_n is low the state is 0000, and a falling rst_n clears it without waiting for a clock edge. The release of rst_n passes through SYNC_STAGES flip-flops (default 2) before counting can start.
- R2: With cnt_en high, tst_load low and a state from 0000 to 1000, the state after the next rising edge is one higher.
- R3: With cnt_en high, tst_load low and the state 1001, the state after the next rising edge is 0000.
- R4: From any state 1010 to 1111 with tst_load low, the state after the next rising edge is 0000, whatever the value of cnt_en.
- R5: With cnt_en low, tst_load low and a state from 0000 to 1001, the state does not change at a rising edge.
- R6: tc_o is high exactly when the state is 1001 and cnt_en is high.
- R7: With tst_load high, the state after the next rising edge equals tst_value, with bit 3 the most significant. This holds for any tst_value and takes priority over cnt_en and over the recovery of R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count enable |
| tst_load | input | 1 | Test hook: write tst_value on the next edge |
| tst_value | input | 4 | Test hook: code to write |
| count_q | output | 4 | Current digit, bit 3 most significant |
| tc_o | output | 1 | Terminal count: state is nine and cnt_en is high |

## Verification
The bench loads each of the six unused codes and checks that one edge brings it back to zero. It does this both with the enable high and with it low. A design that gated recovery with the enable would stay stuck, and wrong excitation terms would land on some other code. The wrap from nine to zero is checked directly: a faulty K term on bit 3 or bit 0 would show up there as 1000, 1001 or a jump to ten. The flag is checked on nine with the enable low, where a flag that ignored the enable would fire too early for a cascade. A mid-cycle reset is checked without any clock edge, to catch a reset that was made synchronous by mistake.

// File: rtl/decade_pkg.sv
package decade_pkg;

  localparam int unsigned CNT_W = 4;

  // Highest legal code; the digit after it is zero.
  localparam logic [CNT_W-1:0] LAST_DIGIT = 4'd9;

  typedef struct packed {
    logic j;
    logic k;
  } jk_pair_t;

  typedef jk_pair_t [CNT_W-1:0] jk_vec_t;

endpackage

// File: rtl/decade_rst_sync.sv
module decade_rst_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [SYNC_STAGES-1:0] chain_q;
  logic [SYNC_STAGES-1:0] chain_d;

  // Shift a one in; assertion is asynchronous, release follows the clock.
  always_comb begin
    chain_d = {chain_q[SYNC_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[SYNC_STAGES-1];

endmodule

// File: rtl/decade_jk_cell.sv
module decade_jk_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic j,
  input  logic k,
  output logic q
);

  logic q_next;

  // JK behaviour: 00 hold, 01 clear, 10 set, 11 toggle.
  always_comb begin
    unique case ({j, k})
      2'b00:   q_next = q;
      2'b01:   q_next = 1'b0;
      2'b10:   q_next = 1'b1;
      default: q_next = ~q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else begin
      q <= q_next;
    end
  end

endmodule

// File: rtl/decade_excite.sv
module decade_excite
  import decade_pkg::*;
(
  input  logic [CNT_W-1:0] state_i,
  input  logic             cnt_en_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output jk_vec_t          jk_o
);

  logic    s3, s2, s1, s0;
  logic    unused_code;
  logic    step_en;
  jk_vec_t count_jk;

  assign {s3, s2, s1, s0} = state_i;

  // Codes 1010..1111: bit 3 set together with bit 2 or bit 1.
  assign unused_code = s3 & (s2 | s1);

  // Recovery from an unused code is not gated by the enable.
  assign step_en = cnt_en_i | unused_code;

  // Minimised equations (unused codes treated as don't-care where their
  // successor 0000 permits).
  always_comb begin
    count_jk[0].j = ~s3 | (~s2 & ~s1);
    count_jk[0].k = 1'b1;
    count_jk[1].j = ~s3 & s0;
    count_jk[1].k = s3 | s0;
    count_jk[2].j = ~s3 & s1 & s0;
    count_jk[2].k = s3 | (s1 & s0);
    count_jk[3].j = s2 & s1 & s0;
    count_jk[3].k = s2 | s1 | s0;
  end

  // Load forces set/clear per bit; otherwise count or hold.
  always_comb begin
    for (int b = 0; b < int'(CNT_W); b++) begin
      if (load_i) begin
        jk_o[b].j = load_val_i[b];
        jk_o[b].k = ~load_val_i[b];
      end else if (step_en) begin
        jk_o[b] = count_jk[b];
      end else begin
        jk_o[b].j = 1'b0;
        jk_o[b].k = 1'b0;
      end
    end
  end

endmodule

// File: rtl/decade_jk_counter.sv
module decade_jk_counter
  import decade_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             tst_load,
  input  logic [CNT_W-1:0] tst_value,
  output logic [CNT_W-1:0] count_q,
  output logic             tc_o
);

  logic    core_rst_n;
  jk_vec_t jk_in;

  decade_rst_sync #(
    .SYNC_STAGES(SYNC_STAGES)
  ) rst_sync_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(core_rst_n)
  );

  decade_excite excite_i (
    .state_i   (count_q),
    .cnt_en_i  (cnt_en),
    .load_i    (tst_load),
    .load_val_i(tst_value),
    .jk_o      (jk_in)
  );

  for (genvar b = 0; b < int'(CNT_W); b++) begin : g_bit
    decade_jk_cell cell_i (
      .clk  (clk),
      .rst_n(core_rst_n),
      .j    (jk_in[b].j),
      .k    (jk_in[b].k),
      .q    (count_q[b])
    );
  end

  assign tc_o = cnt_en & (count_q == LAST_DIGIT);

endmodule

// File: rtl/decade_jk_counter_chk.sv
module decade_jk_counter_chk (
  input logic       clk,
  input logic       core_rst_n,
  input logic       cnt_en,
  input logic       tst_load,
  input logic [3:0] tst_value,
  input logic [3:0] count_q,
  input logic       tc_o
);

  // R2
  step_up_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (cnt_en && !tst_load && count_q < 4'd9) |=> (count_q == $past(count_q) + 4'd1));

  // R3
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (cnt_en && !tst_load && count_q == 4'd9) |=> (count_q == 4'd0));

  // R4
  recover_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!tst_load && count_q > 4'd9) |=> (count_q == 4'd0));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!cnt_en && !tst_load && count_q <= 4'd9) |=> $stable(count_q));

  // R6
  tc_state_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    tc_o |-> (cnt_en && count_q == 4'd9));

  // R7
  load_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    tst_load |=> (count_q == $past(tst_value)));

endmodule

bind decade_jk_counter decade_jk_counter_chk chk_i (
  .clk       (clk),
  .core_rst_n(core_rst_n),
  .cnt_en    (cnt_en),
  .tst_load  (tst_load),
  .tst_value (tst_value),
  .count_q   (count_q),
  .tc_o      (tc_o)
);

// File: tb/decade_jk_counter_tb.sv
module decade_jk_counter_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cnt_en;
  logic       tst_load;
  logic [3:0] tst_value;
  logic [3:0] count_q;
  logic       tc_o;

  int unsigned checks = 0;
  int unsigned errors = 0;
  logic [3:0]  model;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  decade_jk_counter dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_en   (cnt_en),
    .tst_load (tst_load),
    .tst_value(tst_value),
    .count_q  (count_q),
    .tc_o     (tc_o)
  );

  function automatic logic [3:0] next_digit(input logic [3:0] cur, input logic en,
                                            input logic ld, input logic [3:0] val);
    if (ld)            return val;
    else if (cur > 9)  return 4'd0;
    else if (!en)      return cur;
    else if (cur == 9) return 4'd0;
    else               return cur + 4'd1;
  endfunction

  function automatic string req_of(input logic [3:0] cur, input logic en, input logic ld);
    if (ld)            return "R7";
    else if (cur > 9)  return "R4";
    else if (!en)      return "R5";
    else if (cur == 9) return "R3";
    else               return "R2";
  endfunction

  task automatic check_val(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive at negedge, let one rising edge pass, check at the next negedge.
  task automatic step(input logic en, input logic ld, input logic [3:0] val);
    string req;
    req = req_of(model, en, ld);
    cnt_en = en;
    tst_load = ld;
    tst_value = val;
    @(posedge clk);
    @(negedge clk);
    model = next_digit(model, en, ld, val);
    check_val(req, count_q, model);
    check_val("R6", {3'b0, tc_o}, {3'b0, (en && model == 4'd9)});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1207));
    rst_n = 1'b0;
    cnt_en = 1'b0;
    tst_load = 1'b0;
    tst_value = 4'd0;
    model = 4'd0;
    repeat (3) @(negedge clk);
    check_val("R1", count_q, 4'd0);
    rst_n = 1'b1;
    // Synchronizer latency: counting held off; enable high must not count yet.
    cnt_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_val("R1", count_q, 4'd0);
    step(1'b0, 1'b0, 4'd0);

    // R2 / R3: full cycle and wrap.
    for (int i = 0; i < 12; i++) step(1'b1, 1'b0, 4'd0);

    // R6: nine with enable low keeps tc_o low (checked inside step), R5 hold.
    step(1'b1, 1'b1, 4'd9);
    step(1'b0, 1'b0, 4'd0);
    step(1'b0, 1'b0, 4'd0);
    step(1'b1, 1'b0, 4'd0);

    // R4 / R7: every unused code, recovery with enable high and low.
    for (int v = 10; v < 16; v++) begin
      step(1'b0, 1'b1, 4'(v));
      step(1'b0, 1'b0, 4'd0);
      step(1'b1, 1'b1, 4'(v));
      step(1'b1, 1'b0, 4'd0);
    end

    // R7 priority over recovery: load from an unused code.
    step(1'b1, 1'b1, 4'd13);
    step(1'b0, 1'b1, 4'd5);
    step(1'b0, 1'b0, 4'd0);

    // Constrained random mix.
    for (int i = 0; i < 400; i++) begin
      logic       en;
      logic       ld;
      logic [3:0] val;
      en  = ($urandom % 4) != 0;
      ld  = ($urandom % 12) == 0;
      val = 4'($urandom % 16);
      step(en, ld, val);
    end

    // R1: asynchronous clear mid-cycle, no edge needed.
    step(1'b0, 1'b1, 4'd7);
    #2;
    rst_n = 1'b0;
    #1;
    check_val("R1", count_q, 4'd0);
    @(negedge clk);
    rst_n = 1'b1;
    model = 4'd0;
    cnt_en = 1'b0;
    tst_load = 1'b0;
    repeat (2) @(negedge clk);
    step(1'b1, 1'b0, 4'd0);
    step(1'b1, 1'b0, 4'd0);

    finish_run();
  end

endmodule